// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block holds the fetch address of a small processor whose instruction store has 32K words and is divided into 32 pages of 1024 words each. In every clock cycle it takes one decoded control-flow operation and works out the next fetch address. The operations are: step to the next word, jump, call, return, interrupt return, load the PC from the accumulator, add the accumulator to the PC, and a table add.

The upper five address bits come from a page-select field that the core supplies. They are loaded only by jump, call, move-to-PC and add-to-PC. Every other operation leaves the current page alone.

A 32-entry circular return stack serves both calls and interrupts. An interrupt request has priority over the operation in the same cycle. It saves the accumulator, the status byte and the page-select field into a context register and sends the fetch to word 8 of page 0. An interrupt return then presents that saved context to the core along with a restore strobe.

Top module: `pc_seq`

## Requirements
- R1: After reset the PC is 0, the stack pointer is empty (all stack entries 0) and the saved accumulator, status and page outputs are 0.
- R2: Operation code 0 (next) with no interrupt sets PC to PC+1 modulo 2^15, so 0x7FFF wraps to 0x0000.
- R3: Operation code 1 (jump) loads PC with {page_sel, imm}.
- R4: Operation code 2 (call) pushes PC+1 onto the return stack and loads PC with {page_sel, imm}.
- R5: Operation codes 3 (return, also used for return-with-literal) and 4 (interrupt return) load PC from the top of the stack and pop it.
- R6: Operation code 5 (move accumulator to PC) loads PC with {page_sel, 2'b00, acc}.
- R7: Operation code 6 (add accumulator to PC) loads PC with {page_sel, 2'b00, (PC[7:0]+acc) mod 256}.
- R8: Operation code 7 (table add) loads PC[7:0] with (PC[7:0]+acc) mod 256 and leaves PC[14:8] unchanged.
- R9: When irq is high the operation code is ignored. The current PC is pushed, PC becomes 0x0008, and acc, status_in and page_sel are captured into ctx_acc, ctx_status and ctx_page.
- R10: ctx_restore is high exactly in a cycle with operation code 4 and no irq, while ctx_* show the context saved by the last interrupt.
- R11: The stack is LIFO with 32 entries and wraps circularly. A 33rd push overwrites the oldest entry, and a pop from an empty stack reads entry 31 of the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Decoded control-flow operation code |
| imm | input | 10 | Instruction immediate (page offset) |
| acc | input | 8 | Accumulator value |
| status_in | input | 8 | Status byte to save on interrupt |
| page_sel | input | 5 | Page-select field |
| irq | input | 1 | Interrupt request, taken in the cycle it is high |
| pc | output | 15 | Fetch address |
| ctx_acc | output | 8 | Saved accumulator |
| ctx_status | output | 8 | Saved status byte |
| ctx_page | output | 5 | Saved page-select field |
| ctx_restore | output | 1 | Strobe telling the core to reload the saved context |

## Verification
The bench goes after the places where the page bits and bits 8–9 are easy to get wrong. A table add that cleared bits 8–9, or an add-to-PC that kept them, would land in the wrong 256-word window. A jump that ignored page_sel would stay in the old page. A carry out of bit 7 that leaked upward would move the PC by 256 words. The bench runs the increment through 0x7FFF, where a missing wrap shows up as a stray address. It fills the stack to 33 entries and pops past empty, where a saturating or off-by-one pointer would return the wrong addresses. It raises an interrupt during a call, where a design that let the op through would push PC+1 instead of PC and lose the vector.

// File: rtl/pc_seq.sv
module pc_seq #(
  parameter int PAGE_W  = 5,
  parameter int OFF_W   = 10,
  parameter int ACC_W   = 8,
  parameter int STAT_W  = 8,
  parameter int DEPTH   = 32,
  parameter int IRQ_VEC = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2:0]                op,
  input  logic [OFF_W-1:0]          imm,
  input  logic [ACC_W-1:0]          acc,
  input  logic [STAT_W-1:0]         status_in,
  input  logic [PAGE_W-1:0]         page_sel,
  input  logic                      irq,
  output logic [PAGE_W+OFF_W-1:0]   pc,
  output logic [ACC_W-1:0]          ctx_acc,
  output logic [STAT_W-1:0]         ctx_status,
  output logic [PAGE_W-1:0]         ctx_page,
  output logic                      ctx_restore
);
  localparam int PC_W = PAGE_W + OFF_W;
  localparam int SP_W = $clog2(DEPTH);
  localparam int GAP  = OFF_W - ACC_W;

  localparam logic [2:0] OP_NEXT = 3'd0, OP_JMP = 3'd1, OP_CALL = 3'd2, OP_RET = 3'd3,
                         OP_RETI = 3'd4, OP_MOV = 3'd5, OP_ADD = 3'd6, OP_TBL = 3'd7;

  logic [PC_W-1:0] stk [DEPTH];
  logic [SP_W-1:0] sp;
  logic [PC_W-1:0] pc_nx;

  wire              do_push  = irq | (op == OP_CALL);
  wire              do_pop   = !irq & ((op == OP_RET) | (op == OP_RETI));
  wire [SP_W-1:0]   sp_top   = sp - 1'b1;
  wire [PC_W-1:0]   pc_inc   = pc + 1'b1;
  wire [ACC_W-1:0]  low_sum  = pc[ACC_W-1:0] + acc;
  wire [PC_W-1:0]   push_val = irq ? pc : pc_inc;

  assign ctx_restore = !irq & (op == OP_RETI);

  always_comb begin
    if (irq) pc_nx = PC_W'(IRQ_VEC);
    else begin
      case (op)
        OP_JMP, OP_CALL: pc_nx = {page_sel, imm};
        OP_RET, OP_RETI: pc_nx = stk[sp_top];
        OP_MOV:          pc_nx = {page_sel, {GAP{1'b0}}, acc};
        OP_ADD:          pc_nx = {page_sel, {GAP{1'b0}}, low_sum};
        OP_TBL:          pc_nx = {pc[PC_W-1:ACC_W], low_sum};
        default:         pc_nx = pc_inc;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc         <= '0;
      sp         <= '0;
      ctx_acc    <= '0;
      ctx_status <= '0;
      ctx_page   <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else begin
      pc <= pc_nx;
      if (do_push) begin
        stk[sp] <= push_val;
        sp      <= sp + 1'b1;
      end else if (do_pop) begin
        sp <= sp_top;
      end
      if (irq) begin
        ctx_acc    <= acc;
        ctx_status <= status_in;
        ctx_page   <= page_sel;
      end
    end
  end

  a_r1_reset_pc: assert property (@(posedge clk) $rose(rst_n) |-> pc == '0);
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && op == OP_NEXT) |=> pc == $past(pc) + 1'b1);
  a_r3_jump_page: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && op == OP_JMP) |=> pc[PC_W-1:OFF_W] == $past(page_sel));
  a_r6_mov_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && op == OP_MOV) |=> (pc[OFF_W-1:ACC_W] == '0 && pc[ACC_W-1:0] == $past(acc)));
  a_r8_tbl_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && op == OP_TBL) |=> pc[PC_W-1:ACC_W] == $past(pc[PC_W-1:ACC_W]));
  a_r9_irq_vector: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> (pc == PC_W'(IRQ_VEC) && ctx_acc == $past(acc) && ctx_page == $past(page_sel)));
  a_r10_restore_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_restore |-> (op == OP_RETI && !irq));
endmodule

// File: tb/pc_seq_bench.sv
module pc_seq_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic [2:0]  op = 0;
  logic [9:0]  imm = 0;
  logic [7:0]  acc = 0;
  logic [7:0]  status_in = 0;
  logic [4:0]  page_sel = 0;
  logic        irq = 0;
  logic [14:0] pc;
  logic [7:0]  ctx_acc, ctx_status;
  logic [4:0]  ctx_page;
  logic        ctx_restore;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [14:0] m_pc;
  logic [14:0] m_stk [32];
  int          m_sp;
  logic [7:0]  m_cacc, m_cstat;
  logic [4:0]  m_cpage;

  always #5 clk = ~clk;

  pc_seq u_pc_seq (
    .clk(clk), .rst_n(rst_n), .op(op), .imm(imm), .acc(acc), .status_in(status_in),
    .page_sel(page_sel), .irq(irq), .pc(pc), .ctx_acc(ctx_acc), .ctx_status(ctx_status),
    .ctx_page(ctx_page), .ctx_restore(ctx_restore)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_pc = 0; m_sp = 0; m_cacc = 0; m_cstat = 0; m_cpage = 0;
    for (int i = 0; i < 32; i++) m_stk[i] = 0;
  endtask

  task automatic step(input string req, input logic [2:0] o, input logic [9:0] im,
                      input logic [7:0] a, input logic [4:0] pg, input logic iq);
    logic [14:0] nx;
    logic [7:0] lo;
    op = o; imm = im; acc = a; page_sel = pg; irq = iq; status_in = a ^ 8'h5A;
    #1;
    chk("R10 restore strobe", {31'd0, ctx_restore}, {31'd0, (!iq && o == 3'd4)});
    lo = m_pc[7:0] + a;
    if (iq) begin
      nx = 15'd8;
      m_stk[m_sp % 32] = m_pc; m_sp = (m_sp + 1) % 32;
      m_cacc = a; m_cstat = a ^ 8'h5A; m_cpage = pg;
    end else begin
      case (o)
        3'd1: nx = {pg, im};
        3'd2: begin nx = {pg, im}; m_stk[m_sp] = m_pc + 15'd1; m_sp = (m_sp + 1) % 32; end
        3'd3, 3'd4: begin m_sp = (m_sp + 31) % 32; nx = m_stk[m_sp]; end
        3'd5: nx = {pg, 2'b00, a};
        3'd6: nx = {pg, 2'b00, lo};
        3'd7: nx = {m_pc[14:8], lo};
        default: nx = m_pc + 15'd1;
      endcase
    end
    m_pc = nx;
    @(posedge clk);
    @(negedge clk);
    chk(req, {17'd0, pc}, {17'd0, m_pc});
    chk("R9 R10 context", {11'd0, ctx_acc, ctx_status, ctx_page}, {11'd0, m_cacc, m_cstat, m_cpage});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 reset pc", {17'd0, pc}, 32'd0);
    chk("R1 reset context", {11'd0, ctx_acc, ctx_status, ctx_page}, 32'd0);
    step("R1 pop empty after reset", 3'd3, 0, 0, 0, 0);
    step("R2 next", 3'd0, 0, 0, 0, 0);
    step("R2 next", 3'd0, 0, 0, 0, 0);
    step("R3 jump top", 3'd1, 10'h3FF, 0, 5'd31, 0);
    step("R2 wrap 7FFF", 3'd0, 0, 0, 0, 0);
    step("R3 jump", 3'd1, 10'h3F0, 0, 5'd3, 0);
    step("R8 tbl carry stays low", 3'd7, 0, 8'h20, 5'd9, 0);
    step("R6 move", 3'd5, 0, 8'hA5, 5'd17, 0);
    step("R3 jump", 3'd1, 10'h3F8, 0, 5'd2, 0);
    step("R7 add clears 9:8", 3'd6, 0, 8'h10, 5'd4, 0);
    step("R4 call", 3'd2, 10'h123, 0, 5'd7, 0);
    step("R4 call", 3'd2, 10'h2AA, 0, 5'd1, 0);
    step("R9 irq over call", 3'd2, 10'h055, 8'h3C, 5'd21, 1);
    step("R2 in isr", 3'd0, 0, 0, 0, 0);
    step("R5 R10 reti", 3'd4, 0, 0, 0, 0);
    step("R5 ret", 3'd3, 0, 0, 0, 0);
    step("R5 ret", 3'd3, 0, 0, 0, 0);
    for (int i = 0; i < 33; i++) step("R11 deep call", 3'd2, 10'(i * 7), 0, 5'(i), 0);
    for (int i = 0; i < 34; i++) step("R11 deep ret", 3'd3, 0, 0, 0, 0);
    for (int i = 0; i < 300; i++) begin
      logic [2:0] o;
      o = 3'($urandom_range(0, 7));
      step("R2-mixed ops", o, 10'($urandom), 8'($urandom), 5'($urandom), ($urandom_range(0, 15) == 0));
    end
    rst_n = 0;
    @(posedge clk); @(negedge clk);
    model_reset();
    rst_n = 1;
    chk("R1 second reset", {17'd0, pc}, 32'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule